// File: doc/BRIEF.md
# Three-Voice Sound Generator Register Front End

This block sits between a host bus and the datapaths of a three-voice sound generator. The host presents a 5-bit address and an 8-bit data byte. A write updates one field: a voice's pitch, pulse width, control byte or envelope timing byte, or a shared filter setting (cutoff, resonance and voice routing, or filter mode, voice-3 mute and master volume). Every field is held in a register and driven straight to the voice and filter logic. A control write also raises a one-cycle strobe to the oscillator and to the envelope generator of that voice.

Reads are combinational from the address. Two addresses return the oscillator byte and the envelope byte of the third voice, which arrive on input ports. Two paddle addresses always read zero. Every other address is write-only and returns a bus latch instead. The latch holds the last byte written to any address. It keeps that value for a fixed number of cycles after the write and then reads zero. This mimics a floating data bus that decays.

Top module: `snd_regbus`

## Requirements
- R1: Voice v (0 to 2) is written at base address 7·v. Offset 0 sets bits 7:0 and offset 1 sets bits 15:8 of that voice's 16-bit pitch word. Each byte write leaves the other byte unchanged.
- R2: Offset 2 sets bits 7:0 of the voice's 12-bit pulse width. Offset 3 stores only data bits 3:0, into pulse-width bits 11:8.
- R3: Offset 4 stores the whole byte as the voice control byte. In the cycle after the write edge, both the oscillator strobe and the envelope strobe of that voice are high and every other voice's strobes are low. Both strobes are low again one cycle later unless another control write occurs.
- R4: Offset 5 stores the attack/decay byte and offset 6 stores the sustain/release byte of the voice, each as a whole byte.
- R5: Address 0x15 writes data bits 2:0 into cutoff bits 2:0. Address 0x16 writes the data byte into cutoff bits 10:3 of the 11-bit cutoff.
- R6: Address 0x17 sets resonance from data bits 7:4 and the routing mask from bits 3:0. Address 0x18 sets the voice-3 mute from bit 7, the filter mode from bits 6:4 and the volume from bits 3:0.
- R7: Reading 0x19 or 0x1A returns 0x00. Reading 0x1B returns the voice-3 oscillator input byte. Reading 0x1C returns the voice-3 envelope input byte.
- R8: Reading any other address returns the byte of the most recent write to any address.
- R9: After a write, the latch value is readable for LIFE_CYCLES clock cycles and then reads 0x00. A new write reloads the full lifetime.
- R10: A write to an address from 0x19 to 0x1F updates the bus latch and changes no voice or filter register.
- R11: A synchronous active-low reset clears every register, both strobes, the latch and its lifetime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write enable for the current address and data |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| osc3_rd | input | 8 | Voice-3 oscillator byte for readback |
| env3_rd | input | 8 | Voice-3 envelope byte for readback |
| voice_pitch | output | 48 | Pitch words, voice v in bits 16v+15:16v |
| voice_pw | output | 36 | Pulse widths, voice v in bits 12v+11:12v |
| voice_ctrl | output | 24 | Control bytes, voice v in bits 8v+7:8v |
| voice_atk_dcy | output | 24 | Attack/decay bytes per voice |
| voice_sus_rel | output | 24 | Sustain/release bytes per voice |
| osc_ctrl_stb | output | 3 | Control-write strobe to each oscillator |
| env_ctrl_stb | output | 3 | Control-write strobe to each envelope generator |
| flt_cutoff | output | 11 | Filter cutoff |
| flt_res | output | 4 | Filter resonance |
| flt_route | output | 4 | Voice-to-filter routing mask |
| v3_mute | output | 1 | Voice-3 mute |
| flt_mode | output | 3 | Highpass/bandpass/lowpass select |
| master_vol | output | 4 | Output volume |

## Verification
The hardest event to reach is the end of the latch lifetime. It needs thousands of idle cycles with the read address parked on a write-only location, and the last cycle before the clear has to be told apart from the first cycle after it. The bench writes a byte, then waits exactly one cycle short of the lifetime and samples, then waits one more cycle and samples again. It also performs a second write partway through a lifetime to show that the count restarts from the new write and not from the old one. The field map is swept over every voice offset and filter address with several bit patterns. After each write all outputs are compared, so a write that lands on the wrong field is caught.

// File: rtl/snd_regbus_pkg.sv
// Package: shared constants and field encodings for the sound register front end.
// Assumes a 5-bit address space with three voices of seven registers each.
package snd_regbus_pkg;

    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 8;
    localparam int NUM_VOICES = 3;
    localparam int VOICE_SPAN = 7;
    localparam int PITCH_W    = 16;
    localparam int PW_W       = 12;
    localparam int CUT_W      = 11;
    localparam int CUT_LO_W   = 3;

    // Offset of each field inside a voice's address window
    typedef enum logic [2:0] {
        VF_PITCH_LO = 3'd0,
        VF_PITCH_HI = 3'd1,
        VF_PW_LO    = 3'd2,
        VF_PW_HI    = 3'd3,
        VF_CTRL     = 3'd4,
        VF_ATK_DCY  = 3'd5,
        VF_SUS_REL  = 3'd6
    } vfield_e;

    // Shared filter and mixer addresses
    localparam logic [ADDR_W-1:0] A_CUT_LO    = 5'h15;
    localparam logic [ADDR_W-1:0] A_CUT_HI    = 5'h16;
    localparam logic [ADDR_W-1:0] A_RES_ROUTE = 5'h17;
    localparam logic [ADDR_W-1:0] A_MODE_VOL  = 5'h18;

    // Read-only addresses
    localparam logic [ADDR_W-1:0] A_PADDLE_X  = 5'h19;
    localparam logic [ADDR_W-1:0] A_PADDLE_Y  = 5'h1A;
    localparam logic [ADDR_W-1:0] A_OSC3      = 5'h1B;
    localparam logic [ADDR_W-1:0] A_ENV3      = 5'h1C;

    // Shared filter configuration
    typedef struct packed {
        logic [CUT_W-1:0] cutoff;
        logic [3:0]       res;
        logic [3:0]       route;
        logic             v3_mute;
        logic [2:0]       mode;
        logic [3:0]       vol;
    } flt_cfg_t;

endpackage

// File: rtl/snd_voice_regs.sv
// Module: register set of one voice. It decodes its own seven-address window,
// which starts at BASE, holds pitch, pulse width, control and envelope bytes,
// and pulses a control strobe for one cycle after a control write.
// Assumes BASE + VOICE_SPAN fits in the address space.
module snd_voice_regs
    import snd_regbus_pkg::*;
#(
    parameter int BASE = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [PITCH_W-1:0]  pitch,
    output logic [PW_W-1:0]     pw,
    output logic [DATA_W-1:0]   ctrl,
    output logic [DATA_W-1:0]   atk_dcy,
    output logic [DATA_W-1:0]   sus_rel,
    output logic                osc_stb,
    output logic                env_stb
);

    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(VOICE_SPAN);
    localparam int PW_HI_W = PW_W - DATA_W;

    logic [ADDR_W-1:0] rel;
    logic              hit;
    vfield_e           field;
    logic              ctrl_stb_q;

    // Offset within the window; an address below BASE wraps to a large value and misses
    always_comb begin
        rel   = addr - BASE_A;
        hit   = wr_en && (rel < SPAN_A);
        field = vfield_e'(rel[2:0]);
    end

    // Field registers, updated on a write that hits this voice
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pitch   <= '0;
            pw      <= '0;
            ctrl    <= '0;
            atk_dcy <= '0;
            sus_rel <= '0;
        end else if (hit) begin
            case (field)
                VF_PITCH_LO: pitch[DATA_W-1:0]       <= wdata;
                VF_PITCH_HI: pitch[PITCH_W-1:DATA_W] <= wdata;
                VF_PW_LO:    pw[DATA_W-1:0]          <= wdata;
                VF_PW_HI:    pw[PW_W-1:DATA_W]       <= wdata[PW_HI_W-1:0];
                VF_CTRL:     ctrl                    <= wdata;
                VF_ATK_DCY:  atk_dcy                 <= wdata;
                VF_SUS_REL:  sus_rel                 <= wdata;
                default:     ;
            endcase
        end
    end

    // One-cycle control strobe, aligned with the new control byte
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_stb_q <= 1'b0;
        else        ctrl_stb_q <= hit && (field == VF_CTRL);
    end

    assign osc_stb = ctrl_stb_q;
    assign env_stb = ctrl_stb_q;

endmodule

// File: rtl/snd_filter_regs.sv
// Module: shared filter and mixer settings. It decodes the four filter
// addresses and packs the fields into one configuration struct.
// Assumes the filter addresses are distinct from every voice window.
module snd_filter_regs
    import snd_regbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output flt_cfg_t          cfg
);

    // Field updates for the cutoff, resonance/route and mode/volume addresses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CUT_LO:    cfg.cutoff[CUT_LO_W-1:0]     <= wdata[CUT_LO_W-1:0];
                A_CUT_HI:    cfg.cutoff[CUT_W-1:CUT_LO_W] <= wdata;
                A_RES_ROUTE: begin
                    cfg.res   <= wdata[7:4];
                    cfg.route <= wdata[3:0];
                end
                A_MODE_VOL:  begin
                    cfg.v3_mute <= wdata[7];
                    cfg.mode    <= wdata[6:4];
                    cfg.vol     <= wdata[3:0];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/snd_bus_latch.sv
// Module: decaying bus latch. Each write captures the data byte and loads
// a lifetime counter. When the counter expires the byte is cleared.
// Assumes LIFE_CYCLES >= 1.
module snd_bus_latch
    import snd_regbus_pkg::*;
#(
    parameter int LIFE_CYCLES = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] latch
);

    localparam int CNT_W = $clog2(LIFE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIFE_V = CNT_W'(LIFE_CYCLES);
    localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

    logic [CNT_W-1:0] ttl;

    // Capture on write, count down otherwise, clear on the final count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch <= '0;
            ttl   <= '0;
        end else if (wr_en) begin
            latch <= wdata;
            ttl   <= LIFE_V;
        end else if (ttl != '0) begin
            ttl <= ttl - ONE_V;
            if (ttl == ONE_V) latch <= '0;
        end
    end

endmodule

// File: rtl/snd_read_mux.sv
// Module: combinational read-data selection. The paddle addresses read
// zero, the voice-3 readbacks come from inputs, and everything else
// reads the bus latch.
module snd_read_mux
    import snd_regbus_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] osc3_rd,
    input  logic [DATA_W-1:0] env3_rd,
    input  logic [DATA_W-1:0] latch,
    output logic [DATA_W-1:0] rdata
);

    // Address-driven source select
    always_comb begin
        case (addr)
            A_PADDLE_X, A_PADDLE_Y: rdata = '0;
            A_OSC3:                 rdata = osc3_rd;
            A_ENV3:                 rdata = env3_rd;
            default:                rdata = latch;
        endcase
    end

endmodule

// File: rtl/snd_regbus.sv
// Module: top of the sound register front end. It instantiates one register
// set per voice, the shared filter settings, the decaying bus latch and the
// read multiplexer, and flattens the per-voice fields onto packed ports.
// Assumes single-cycle writes and reads that are sampled combinationally.
module snd_regbus
    import snd_regbus_pkg::*;
#(
    parameter int LIFE_CYCLES = 8192
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [4:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic [7:0]  osc3_rd,
    input  logic [7:0]  env3_rd,
    output logic [47:0] voice_pitch,
    output logic [35:0] voice_pw,
    output logic [23:0] voice_ctrl,
    output logic [23:0] voice_atk_dcy,
    output logic [23:0] voice_sus_rel,
    output logic [2:0]  osc_ctrl_stb,
    output logic [2:0]  env_ctrl_stb,
    output logic [10:0] flt_cutoff,
    output logic [3:0]  flt_res,
    output logic [3:0]  flt_route,
    output logic        v3_mute,
    output logic [2:0]  flt_mode,
    output logic [3:0]  master_vol
);

    flt_cfg_t          cfg;
    logic [DATA_W-1:0] latch;

    // One register set per voice, each with its own address window
    for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
        snd_voice_regs #(
            .BASE (v * VOICE_SPAN)
        ) voice_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .addr    (addr),
            .wdata   (wdata),
            .pitch   (voice_pitch[v*PITCH_W +: PITCH_W]),
            .pw      (voice_pw[v*PW_W +: PW_W]),
            .ctrl    (voice_ctrl[v*DATA_W +: DATA_W]),
            .atk_dcy (voice_atk_dcy[v*DATA_W +: DATA_W]),
            .sus_rel (voice_sus_rel[v*DATA_W +: DATA_W]),
            .osc_stb (osc_ctrl_stb[v]),
            .env_stb (env_ctrl_stb[v])
        );
    end

    snd_filter_regs flt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .cfg   (cfg)
    );

    snd_bus_latch #(
        .LIFE_CYCLES (LIFE_CYCLES)
    ) latch_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .wdata (wdata),
        .latch (latch)
    );

    snd_read_mux rmux_i (
        .addr    (addr),
        .osc3_rd (osc3_rd),
        .env3_rd (env3_rd),
        .latch   (latch),
        .rdata   (rdata)
    );

    // Unpack the filter struct onto the individual ports
    always_comb begin
        flt_cutoff = cfg.cutoff;
        flt_res    = cfg.res;
        flt_route  = cfg.route;
        v3_mute    = cfg.v3_mute;
        flt_mode   = cfg.mode;
        master_vol = cfg.vol;
    end

endmodule

// File: rtl/snd_regbus_chk.sv
// Module: assertion checker for snd_regbus, attached by bind. It tracks the
// cycles since the last write with its own counter to check latch expiry.
module snd_regbus_chk #(
    parameter int LIFE_CYCLES = 8192
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [4:0]  addr,
    input logic [7:0]  wdata,
    input logic [7:0]  rdata,
    input logic [7:0]  osc3_rd,
    input logic [7:0]  env3_rd,
    input logic [2:0]  osc_ctrl_stb,
    input logic [2:0]  env_ctrl_stb,
    input logic [10:0] flt_cutoff,
    input logic [3:0]  flt_res,
    input logic [3:0]  master_vol,
    input logic [47:0] voice_pitch
);

    localparam int AGE_W = $clog2(LIFE_CYCLES + 1);
    localparam logic [AGE_W-1:0] LIFE_V = AGE_W'(LIFE_CYCLES);

    logic [AGE_W-1:0] age;
    logic             seen_wr;
    logic             latch_addr;

    assign latch_addr = (addr < 5'h19) || (addr > 5'h1C);

    // Saturating count of cycles since the most recent write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age     <= '0;
            seen_wr <= 1'b0;
        end else if (wr_en) begin
            age     <= '0;
            seen_wr <= 1'b1;
        end else if (age != LIFE_V) begin
            age <= age + AGE_W'(1);
        end
    end

    // R3: a single address strobes at most one voice
    p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(osc_ctrl_stb) && $onehot0(env_ctrl_stb));

    // R3: a control write to voice 0 strobes both of its consumers next cycle
    p_ctrl_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_en) && ($past(addr) == 5'h04)
        |-> osc_ctrl_stb[0] && env_ctrl_stb[0]);

    // R7: paddle addresses read zero
    p_paddle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 5'h19 || addr == 5'h1A) |-> rdata == 8'h00);

    // R7: voice-3 readbacks pass through
    p_voice3_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr == 5'h1B) |-> rdata == osc3_rd) and ((addr == 5'h1C) |-> rdata == env3_rd));

    // R8: the cycle after a write, a write-only address reads that byte
    p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_en) && latch_addr |-> rdata == $past(wdata));

    // R9: once the lifetime has run out (or nothing was written), the latch reads zero
    p_latch_expire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_wr || age == LIFE_V) && latch_addr |-> rdata == 8'h00);

    // R10: a write above the register range leaves the registers untouched
    p_high_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_en) && ($past(addr) > 5'h18)
        |-> $stable(flt_cutoff) && $stable(flt_res) && $stable(master_vol) && $stable(voice_pitch));

endmodule

bind snd_regbus snd_regbus_chk #(
    .LIFE_CYCLES (LIFE_CYCLES)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .osc3_rd      (osc3_rd),
    .env3_rd      (env3_rd),
    .osc_ctrl_stb (osc_ctrl_stb),
    .env_ctrl_stb (env_ctrl_stb),
    .flt_cutoff   (flt_cutoff),
    .flt_res      (flt_res),
    .master_vol   (master_vol),
    .voice_pitch  (voice_pitch)
);

// File: tb/snd_regbus_tb_top.sv
module snd_regbus_tb_top;

    localparam int LIFE = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  osc3_rd = '0;
    logic [7:0]  env3_rd = '0;
    logic [7:0]  rdata;
    logic [47:0] voice_pitch;
    logic [35:0] voice_pw;
    logic [23:0] voice_ctrl, voice_atk_dcy, voice_sus_rel;
    logic [2:0]  osc_ctrl_stb, env_ctrl_stb;
    logic [10:0] flt_cutoff;
    logic [3:0]  flt_res, flt_route, master_vol;
    logic        v3_mute;
    logic [2:0]  flt_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // expected state, from the requirements
    logic [15:0] e_pitch [3];
    logic [11:0] e_pw    [3];
    logic [7:0]  e_ctrl  [3];
    logic [7:0]  e_ad    [3];
    logic [7:0]  e_sr    [3];
    logic [10:0] e_cut;
    logic [3:0]  e_res, e_route, e_vol;
    logic        e_mute;
    logic [2:0]  e_mode;
    logic [7:0]  e_latch;

    always #5 clk = ~clk;

    snd_regbus #(.LIFE_CYCLES(LIFE)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .osc3_rd(osc3_rd), .env3_rd(env3_rd),
        .voice_pitch(voice_pitch), .voice_pw(voice_pw), .voice_ctrl(voice_ctrl),
        .voice_atk_dcy(voice_atk_dcy), .voice_sus_rel(voice_sus_rel),
        .osc_ctrl_stb(osc_ctrl_stb), .env_ctrl_stb(env_ctrl_stb),
        .flt_cutoff(flt_cutoff), .flt_res(flt_res), .flt_route(flt_route),
        .v3_mute(v3_mute), .flt_mode(flt_mode), .master_vol(master_vol)
    );

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int v = 0; v < 3; v++) begin
            e_pitch[v] = '0; e_pw[v] = '0; e_ctrl[v] = '0; e_ad[v] = '0; e_sr[v] = '0;
        end
        e_cut = '0; e_res = '0; e_route = '0; e_vol = '0; e_mute = 1'b0; e_mode = '0;
        e_latch = '0;
    endtask

    task automatic model_write(input int a, input logic [7:0] d);
        e_latch = d;
        if (a < 21) begin
            int v;
            int o;
            v = a / 7;
            o = a % 7;
            case (o)
                0: e_pitch[v][7:0]  = d;
                1: e_pitch[v][15:8] = d;
                2: e_pw[v][7:0]     = d;
                3: e_pw[v][11:8]    = d[3:0];
                4: e_ctrl[v]        = d;
                5: e_ad[v]          = d;
                default: e_sr[v]    = d;
            endcase
        end else begin
            case (a)
                21: e_cut[2:0]  = d[2:0];
                22: e_cut[10:3] = d;
                23: begin e_res = d[7:4]; e_route = d[3:0]; end
                24: begin e_mute = d[7]; e_mode = d[6:4]; e_vol = d[3:0]; end
                default: ;
            endcase
        end
    endtask

    // compare every register output; ovr replaces the per-field requirement tag
    task automatic check_all(input string ovr);
        for (int v = 0; v < 3; v++) begin
            chk(ovr == "" ? "R1" : ovr, $sformatf("pitch v%0d", v), int'(voice_pitch[v*16 +: 16]), int'(e_pitch[v]));
            chk(ovr == "" ? "R2" : ovr, $sformatf("pw v%0d", v), int'(voice_pw[v*12 +: 12]), int'(e_pw[v]));
            chk(ovr == "" ? "R3" : ovr, $sformatf("ctrl v%0d", v), int'(voice_ctrl[v*8 +: 8]), int'(e_ctrl[v]));
            chk(ovr == "" ? "R4" : ovr, $sformatf("atk_dcy v%0d", v), int'(voice_atk_dcy[v*8 +: 8]), int'(e_ad[v]));
            chk(ovr == "" ? "R4" : ovr, $sformatf("sus_rel v%0d", v), int'(voice_sus_rel[v*8 +: 8]), int'(e_sr[v]));
        end
        chk(ovr == "" ? "R5" : ovr, "cutoff", int'(flt_cutoff), int'(e_cut));
        chk(ovr == "" ? "R6" : ovr, "res", int'(flt_res), int'(e_res));
        chk(ovr == "" ? "R6" : ovr, "route", int'(flt_route), int'(e_route));
        chk(ovr == "" ? "R6" : ovr, "mute", int'(v3_mute), int'(e_mute));
        chk(ovr == "" ? "R6" : ovr, "mode", int'(flt_mode), int'(e_mode));
        chk(ovr == "" ? "R6" : ovr, "vol", int'(master_vol), int'(e_vol));
    endtask

    // one write cycle; returns at the falling edge after the write edge
    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 5'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic check_read(input string req, input int a, input int exp);
        addr = 5'(a);
        #1;
        chk(req, $sformatf("rdata @0x%0h", a), int'(rdata), exp);
    endtask

    logic [7:0] pats [5] = '{8'hA5, 8'h5A, 8'hFF, 8'h00, 8'h3C};

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: state after reset
        check_all("R11");
        chk("R11", "osc strobes", int'(osc_ctrl_stb), 0);
        check_read("R11", 5, 0);

        // R1 R2 R3 R4: sweep every voice offset with several patterns
        for (int v = 0; v < 3; v++) begin
            for (int o = 0; o < 7; o++) begin
                for (int p = 0; p < 5; p++) begin
                    logic [7:0] d;
                    int exp_stb;
                    d = pats[p] ^ 8'(v * 16 + o);
                    wr(v * 7 + o, d);
                    exp_stb = (o == 4) ? (1 << v) : 0;
                    check_all("");
                    chk("R3", "osc strobe", int'(osc_ctrl_stb), exp_stb);
                    chk("R3", "env strobe", int'(env_ctrl_stb), exp_stb);
                    @(negedge clk);
                    chk("R3", "osc strobe drop", int'(osc_ctrl_stb), 0);
                    chk("R3", "env strobe drop", int'(env_ctrl_stb), 0);
                end
            end
        end

        // R3: back-to-back control writes to two voices
        wr(4, 8'h41);
        chk("R3", "osc strobe b2b first", int'(osc_ctrl_stb), 1);
        wr(11, 8'h81);
        chk("R3", "osc strobe b2b second", int'(osc_ctrl_stb), 2);
        chk("R3", "env strobe b2b second", int'(env_ctrl_stb), 2);

        // R5 R6: sweep the filter addresses
        for (int a = 21; a <= 24; a++) begin
            for (int p = 0; p < 5; p++) begin
                wr(a, pats[p] ^ 8'(a));
                check_all("");
            end
        end
        wr(21, 8'hFD);
        wr(22, 8'h96);
        check_all("R5");

        // R10: writes above the register range change only the latch
        for (int a = 25; a < 32; a++) begin
            wr(a, 8'(a * 7 + 3));
            check_all("R10");
            check_read("R10", 29, int'(e_latch));
        end

        // R7 R8: read sweep of every address after a write
        wr(13, 8'hB7);
        for (int a = 0; a < 32; a++) begin
            int exp;
            osc3_rd = 8'(a * 3 + 1);
            env3_rd = ~8'(a);
            if (a == 25 || a == 26)      exp = 0;
            else if (a == 27)            exp = int'(osc3_rd);
            else if (a == 28)            exp = int'(env3_rd);
            else                         exp = int'(e_latch);
            check_read((a >= 25 && a <= 28) ? "R7" : "R8", a, exp);
        end

        // R9: latch lasts exactly LIFE cycles
        wr(31, 8'hC3);
        repeat (LIFE - 1) @(negedge clk);
        check_read("R9", 31, 'hC3);
        @(negedge clk);
        check_read("R9", 31, 0);
        check_read("R9", 2, 0);

        // R9: a second write restarts the lifetime
        wr(31, 8'h11);
        repeat (100) @(negedge clk);
        wr(2, 8'h77);
        addr = 5'h1F;
        repeat (LIFE - 1) @(negedge clk);
        check_read("R9", 31, 'h77);
        @(negedge clk);
        check_read("R9", 31, 0);
        check_all("");

        // R11: reset in mid-run clears everything
        wr(0, 8'h12);
        wr(24, 8'hFF);
        wr(12, 8'h34);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check_all("R11");
        check_read("R11", 30, 0);
        chk("R11", "env strobes", int'(env_ctrl_stb), 0);

        summary();
    end

endmodule